// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This block lets each of four cores raise an interrupt on any other core and lets a receiving core find out which cores signalled it. Every core has its own command port: a strobe, a two-bit opcode, a two-bit core-number argument, a ready return, and a readback word with a valid flag. The block keeps a sender-by-receiver pending matrix. Each core's interrupt line is the registered OR of that core's receiver column.

Several senders aimed at one receiver merge into one asserted line. The receiver issues a source query, gets back a bitmask with one bit per sender, and clears each sender with its own acknowledge. When several cores strobe in the same cycle, one command is accepted per cycle and the lowest-numbered core wins.

Each port has a readback state machine with two states, RB_IDLE and RB_HOLD. An accepted status or source query moves it to RB_HOLD (the LOAD transition). An accepted raise or clear moves it to RB_IDLE (the DROP transition). With no accepted command it stays where it is (the KEEP transition). A new query in RB_HOLD reloads the data and stays in RB_HOLD.

Top module: `ipi_hub`

## Requirements
- R1: After reset every irq line is 0, every rd_valid is 0, and with no strobe every cmd_ready is 0.
- R2: Opcode 0 (raise) from core i with argument t≠i sets pending[i→t]. irq[t] goes to 1 after the second rising edge that follows acceptance.
- R3: A raise whose argument equals the issuing core sets no pending state, and no irq line changes.
- R4: Opcode 1 (status) with argument t returns rd_data = 1 when any pending bit toward t is set, and 0 otherwise. Bits above bit 0 are 0.
- R5: Opcode 2 (source) from core i returns rd_data with bit n (weight 2^n) set exactly when pending[n→i] is set.
- R6: Raises from several senders to one receiver assert only that receiver's single line, and the source mask shows every one of those senders.
- R7: Opcode 3 (clear) from core i with argument s clears only pending[s→i]. irq[i] stays 1 while any other sender to i is still pending.
- R8: When the last pending bit toward core r is cleared, irq[r] is still 1 after the acceptance edge and is 0 after the next edge.
- R9: With several strobes in the same cycle, cmd_ready is 1 only for the lowest-numbered strobing core. The other cores stall until it drops its strobe.
- R10: After an accepted status or source command, rd_valid and rd_data update at the acceptance edge. They hold until that core's next accepted command, and an accepted raise or clear drops rd_valid.
- R11: A repeated raise for a sender/receiver pair that is already pending has no further effect: one clear removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | NUM_CORES | Command strobe, one per core |
| cmd_op | input | 2*NUM_CORES | Opcode per core (0 raise, 1 status, 2 source, 3 clear) |
| cmd_core | input | CW*NUM_CORES | Target or sender core number per core |
| cmd_ready | output | NUM_CORES | Command accepted this cycle, per core |
| rd_data | output | NUM_CORES*NUM_CORES | Readback word per core |
| rd_valid | output | NUM_CORES | Readback word valid, per core |
| irq | output | NUM_CORES | Interrupt line to each core |

## Verification
The bench targets the following corner cases and the failure each would expose:
- Two senders aimed at one receiver. A design that kept one sender per receiver would return a single-bit source mask.
- A clear while another sender is still pending. A design that cleared the whole column would drop the line early.
- A raise to the issuing core itself. This would light that core's own line.
- A repeated raise. A design that counted raises would need two clears before the line drops.
- Simultaneous strobes. These check that the lowest core is served first and that readback holds across idle cycles.
- A one-cycle check on line deassertion. This catches a line driven straight from the matrix, or one with an extra register stage.

// File: rtl/ipi_hub_pkg.sv
package ipi_hub_pkg;

    typedef enum logic [1:0] {
        OP_RAISE  = 2'd0,
        OP_STATUS = 2'd1,
        OP_SOURCE = 2'd2,
        OP_CLEAR  = 2'd3
    } ipi_op_e;

    typedef enum logic {
        RB_IDLE = 1'b0,
        RB_HOLD = 1'b1
    } rb_state_e;

endpackage

// File: rtl/ipi_hub_arb.sv
module ipi_hub_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipi_hub_pend.sv
module ipi_hub_pend
    import ipi_hub_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          acc,
    input  logic [N-1:0][1:0]     ops,
    input  logic [N-1:0][CW-1:0]  args,
    output logic [N-1:0][N-1:0]   col,   // [receiver][sender]
    output logic [N-1:0]          irq
);
    logic [N-1:0][N-1:0] pend_q, pend_d;   // [sender][receiver]
    logic [N-1:0]        irq_d;

    always_comb begin
        pend_d = pend_q;
        for (int c = 0; c < N; c++) begin
            if (acc[c]) begin
                unique case (ipi_op_e'(ops[c]))
                    OP_RAISE: begin
                        if (args[c] != CW'(c))
                            pend_d[c][args[c]] = 1'b1;
                    end
                    OP_CLEAR:  pend_d[args[c]][c] = 1'b0;
                    OP_STATUS,
                    OP_SOURCE: ;
                endcase
            end
        end
    end

    always_comb begin
        for (int r = 0; r < N; r++) begin
            for (int s = 0; s < N; s++)
                col[r][s] = pend_q[s][r];
            irq_d[r] = |col[r];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            irq    <= '0;
        end else begin
            pend_q <= pend_d;
            irq    <= irq_d;
        end
    end
endmodule

// File: rtl/ipi_hub_rdbk.sv
module ipi_hub_rdbk
    import ipi_hub_pkg::*;
#(
    parameter int N    = 4,
    parameter int CW   = 2,
    parameter int CORE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc,
    input  logic [1:0]          op,
    input  logic [CW-1:0]       arg,
    input  logic [N-1:0][N-1:0] col,
    output logic [N-1:0]        data,
    output logic                valid
);
    rb_state_e  state_q, state_d;
    logic [N-1:0] data_q, data_d;
    logic [N-1:0] result;

    always_comb begin
        result = '0;
        unique case (ipi_op_e'(op))
            OP_STATUS: result[0] = |col[arg];
            OP_SOURCE: result    = col[CORE];
            OP_RAISE,
            OP_CLEAR:  result    = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        data_d  = data_q;
        if (acc) begin
            unique case (ipi_op_e'(op))
                OP_STATUS, OP_SOURCE: begin
                    state_d = RB_HOLD;
                    data_d  = result;
                end
                OP_RAISE, OP_CLEAR: begin
                    state_d = RB_IDLE;
                    data_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RB_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RB_IDLE: begin
                valid = 1'b0;
                data  = '0;
            end
            RB_HOLD: begin
                valid = 1'b1;
                data  = data_q;
            end
        endcase
    end
endmodule

// File: rtl/ipi_hub.sv
module ipi_hub #(
    parameter int NUM_CORES = 4,
    parameter int CW        = $clog2(NUM_CORES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CORES-1:0]           cmd_valid,
    input  logic [2*NUM_CORES-1:0]         cmd_op,
    input  logic [CW*NUM_CORES-1:0]        cmd_core,
    output logic [NUM_CORES-1:0]           cmd_ready,
    output logic [NUM_CORES*NUM_CORES-1:0] rd_data,
    output logic [NUM_CORES-1:0]           rd_valid,
    output logic [NUM_CORES-1:0]           irq
);
    localparam int N = NUM_CORES;

    logic [N-1:0]          gnt;
    logic [N-1:0]          acc;
    logic [N-1:0][1:0]     ops;
    logic [N-1:0][CW-1:0]  args;
    logic [N-1:0][N-1:0]   col;

    assign ops  = cmd_op;
    assign args = cmd_core;

    ipi_hub_arb #(.N(N)) u_arb (
        .req (cmd_valid),
        .gnt (gnt)
    );

    assign cmd_ready = gnt;
    assign acc       = cmd_valid & gnt;

    ipi_hub_pend #(.N(N), .CW(CW)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .ops   (ops),
        .args  (args),
        .col   (col),
        .irq   (irq)
    );

    for (genvar c = 0; c < N; c++) begin : g_port
        ipi_hub_rdbk #(.N(N), .CW(CW), .CORE(c)) u_rdbk (
            .clk   (clk),
            .rst_n (rst_n),
            .acc   (acc[c]),
            .op    (ops[c]),
            .arg   (args[c]),
            .col   (col),
            .data  (rd_data[c*N +: N]),
            .valid (rd_valid[c])
        );
    end
endmodule

// File: rtl/ipi_hub_chk.sv
module ipi_hub_chk #(
    parameter int NUM_CORES = 4,
    parameter int CW        = $clog2(NUM_CORES)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_CORES-1:0]           cmd_valid,
    input logic [2*NUM_CORES-1:0]         cmd_op,
    input logic [CW*NUM_CORES-1:0]        cmd_core,
    input logic [NUM_CORES-1:0]           cmd_ready,
    input logic [NUM_CORES*NUM_CORES-1:0] rd_data,
    input logic [NUM_CORES-1:0]           rd_valid,
    input logic [NUM_CORES-1:0]           irq
);
    localparam int N = NUM_CORES;

    logic [N-1:0] acc, is_read, is_clear, raise_hit, clear_hit;

    always_comb begin
        raise_hit = '0;
        clear_hit = '0;
        for (int c = 0; c < N; c++) begin
            acc[c]      = cmd_valid[c] && cmd_ready[c];
            is_read[c]  = (cmd_op[2*c +: 2] == 2'd1) || (cmd_op[2*c +: 2] == 2'd2);
            is_clear[c] = (cmd_op[2*c +: 2] == 2'd3);
            if (acc[c] && cmd_op[2*c +: 2] == 2'd0 && cmd_core[CW*c +: CW] != CW'(c))
                raise_hit[cmd_core[CW*c +: CW]] = 1'b1;
            if (acc[c] && is_clear[c])
                clear_hit[c] = 1'b1;
        end
    end

    // R9
    lowest_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid[0] |-> cmd_ready[0]);

    // R9
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_ready));

    for (genvar r = 0; r < N; r++) begin : g_chk
        // R2
        rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[r]) |-> $past(raise_hit[r], 2));

        // R8
        fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[r]) |-> $past(clear_hit[r], 2));

        // R10
        rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc[r] && is_read[r]) |=> rd_valid[r]);

        // R10
        rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid[r] && !acc[r]) |=> (rd_valid[r] && $stable(rd_data[r*N +: N])));
    end
endmodule

bind ipi_hub ipi_hub_chk #(.NUM_CORES(NUM_CORES), .CW(CW)) u_chk (.*);

// File: tb/test_ipi_hub.sv
module test_ipi_hub;
    localparam int N  = 4;
    localparam int CW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   cmd_valid = '0;
    logic [2*N-1:0] cmd_op = '0;
    logic [CW*N-1:0] cmd_core = '0;
    logic [N-1:0]   cmd_ready;
    logic [N*N-1:0] rd_data;
    logic [N-1:0]   rd_valid;
    logic [N-1:0]   irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ipi_hub #(.NUM_CORES(N)) i_ipi_hub (.*);

    // {core, op, arg, check_rd, exp_rd, exp_irq}
    localparam int VN = 18;
    localparam logic [14:0] VEC [VN] = '{
        {2'd1, 2'd0, 2'd2, 1'b0, 4'h0, 4'h4},  // R2 core1 raises core2
        {2'd2, 2'd2, 2'd0, 1'b1, 4'h2, 4'h4},  // R5 source mask = core1
        {2'd3, 2'd0, 2'd2, 1'b0, 4'h0, 4'h4},  // R6 second sender merges
        {2'd2, 2'd2, 2'd0, 1'b1, 4'hA, 4'h4},  // R6 mask cores 1,3
        {2'd0, 2'd1, 2'd2, 1'b1, 4'h1, 4'h4},  // R4 status core2 pending
        {2'd0, 2'd1, 2'd1, 1'b1, 4'h0, 4'h4},  // R4 status core1 idle
        {2'd2, 2'd3, 2'd1, 1'b0, 4'h0, 4'h4},  // R7 clear core1 only
        {2'd2, 2'd2, 2'd0, 1'b1, 4'h8, 4'h4},  // R7 core3 still pending
        {2'd2, 2'd3, 2'd3, 1'b0, 4'h0, 4'h0},  // R7 last clear
        {2'd0, 2'd0, 2'd0, 1'b0, 4'h0, 4'h0},  // R3 self raise
        {2'd0, 2'd1, 2'd0, 1'b1, 4'h0, 4'h0},  // R3 nothing pending to self
        {2'd0, 2'd0, 2'd3, 1'b0, 4'h0, 4'h8},  // R11 raise 0->3
        {2'd0, 2'd0, 2'd3, 1'b0, 4'h0, 4'h8},  // R11 repeat
        {2'd3, 2'd3, 2'd0, 1'b0, 4'h0, 4'h0},  // R11 one clear suffices
        {2'd3, 2'd0, 2'd0, 1'b0, 4'h0, 4'h1},  // R2 core3 raises core0
        {2'd0, 2'd2, 2'd0, 1'b1, 4'h8, 4'h1},  // R5 mask weight 8
        {2'd1, 2'd1, 2'd0, 1'b1, 4'h1, 4'h1},  // R4 status from third core
        {2'd0, 2'd3, 2'd3, 1'b0, 4'h0, 4'h0}   // R7 clear
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input int c, input logic [1:0] op, input logic [1:0] arg);
        cmd_valid[c]          = 1'b1;
        cmd_op[2*c +: 2]      = op;
        cmd_core[CW*c +: CW]  = arg;
    endtask

    task automatic issue(input int c, input logic [1:0] op, input logic [1:0] arg);
        @(negedge clk);
        drive(c, op, arg);
        @(negedge clk);
        cmd_valid = '0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", 16'(irq), 16'h0);
        chk("R1 rd_valid", 16'(rd_valid), 16'h0);
        chk("R1 ready", 16'(cmd_ready), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after release", 16'(irq), 16'h0);

        for (int v = 0; v < VN; v++) begin
            logic [14:0] e;
            int c;
            e = VEC[v];
            c = int'(e[14:13]);
            issue(c, e[12:11], e[10:9]);
            chk($sformatf("vec%0d irq (R2/R3/R6/R7/R11)", v), 16'(irq), 16'(e[3:0]));
            if (e[8]) begin
                chk($sformatf("vec%0d rd_data (R4/R5)", v), 16'(rd_data[c*N +: N]), 16'(e[7:4]));
                chk($sformatf("vec%0d rd_valid R10", v), 16'(rd_valid[c]), 16'h1);
            end
        end

        // R8: deassert exactly one edge after the last clear is accepted
        issue(1, 2'd0, 2'd2);
        chk("R8 line up", 16'(irq), 16'h4);
        @(negedge clk);
        drive(2, 2'd3, 2'd1);
        @(negedge clk);
        cmd_valid = '0;
        chk("R8 still high after accept edge", 16'(irq[2]), 16'h1);
        @(negedge clk);
        chk("R8 low one edge later", 16'(irq[2]), 16'h0);

        // R9: simultaneous strobes, lowest wins
        @(negedge clk);
        drive(1, 2'd0, 2'd0);
        drive(2, 2'd0, 2'd0);
        drive(3, 2'd2, 2'd0);
        #1;
        chk("R9 core1 first", 16'(cmd_ready), 16'h2);
        @(negedge clk);
        cmd_valid[1] = 1'b0;
        #1;
        chk("R9 core2 next", 16'(cmd_ready), 16'h4);
        @(negedge clk);
        cmd_valid[2] = 1'b0;
        #1;
        chk("R9 core3 last", 16'(cmd_ready), 16'h8);
        @(negedge clk);
        cmd_valid = '0;
        chk("R9 core3 source after stall", 16'(rd_data[3*N +: N]), 16'h0);
        chk("R6 core0 line", 16'(irq), 16'h1);

        // R10: readback holds across idle cycles, drops on next non-read
        issue(0, 2'd2, 2'd0);
        chk("R10 source 1,2", 16'(rd_data[0 +: N]), 16'h6);
        repeat (4) @(negedge clk);
        chk("R10 hold data", 16'(rd_data[0 +: N]), 16'h6);
        chk("R10 hold valid", 16'(rd_valid[0]), 16'h1);
        issue(1, 2'd3, 2'd0);
        chk("R10 other core leaves readback", 16'(rd_valid[0]), 16'h1);
        issue(0, 2'd3, 2'd1);
        chk("R10 drop valid on clear", 16'(rd_valid[0]), 16'h0);
        chk("R7 core2 remains", 16'(irq), 16'h1);
        issue(0, 2'd3, 2'd2);
        chk("R7 all cleared", 16'(irq), 16'h0);

        finish_run();
    end
endmodule